// File: doc/BRIEF.md
# Stacked Inset-Window Overlay Timing Generator

This block decides, pixel by pixel, what a television output stage should show while up to four small inset pictures are stacked in a vertical column on top of the main picture. It receives the current pixel column and line inside the main picture's active area, together with a set of configuration inputs. For each pixel it reports a source code: main video, inset picture, border colour, fill colour or black. When the code is inset picture, it also reports which window the pixel belongs to and the pixel's column and row inside that window's picture.

A size input picks between a small window of 84 pixels by 53 lines, with up to four windows in the stack, and a large window of 114 pixels by 71 lines, with up to three. Each window has a frame 3 pixels wide at the left and right and 2 lines tall at the top and bottom. Windows sit directly below one another with no gap. Two 6-bit position inputs slide the whole stack across the active area in 64 steps. Each window has its own enable bit and its own blank bit. A 2-bit selector marks one window as the live one. A border colour code and a fill code complete the configuration. Decoding the video, fetching samples from memory and encoding colour all happen outside this block.

Top module: `pip_stack_overlay`

## Requirements
- R1: When size_lg is 0, each window's picture is 84 pixels by 53 lines and there are 4 slots. When size_lg is 1, each picture is 114 by 71 with 3 slots. The stack is (picture width + 6) pixels wide and slots × (picture height + 4) lines tall. Pixels outside the stack give src_sel 0 (main).
- R2: Each slot is a frame of 3 pixels on the left and right and 2 lines on the top and bottom around its picture. Slot k starts on line Y0 + k × (picture height + 4), so each slot's bottom frame touches the next slot's top frame.
- R3: The stack's top-left corner is X0 = floor(xpos × (ACT_W − stack width) / 63) and Y0 = floor(ypos × (ACT_H − stack height) / 63), with coordinates measured from the top-left of the active area.
- R4: win_en bit k (bit 0 is the top slot) turns slot k on. A pixel in a disabled slot gives main. Disabled slots still hold their place, so the other slots do not move. In large mode, bit 3 has no effect.
- R5: If win_blank bit k is set, every picture pixel of slot k gives src_sel 4 (black). The frame of slot k is still drawn.
- R6: border_code 010 and 011 hide the frame, so frame pixels give main. Every other code gives src_sel 2 on frame pixels, with color_code equal to border_code (000 black, 001 70% white, 100 blue, 101 green, 110 red, 111 white).
- R7: A non-zero fill_code (01 red, 10 green, 11 blue) replaces a picture pixel with src_sel 3 and color_code {0, fill_code}. Blank takes priority over fill.
- R8: A visible picture pixel gives src_sel 1, win_idx = slot, win_col = x − X0 − 3 and win_row = line offset in the slot − 2. Its color_code is 0.
- R9: The live slot index is live_sel, except that in large mode code 11 selects slot 2. win_live is 1 exactly on non-main pixels of the live slot.
- R10: Outputs are registered. Inputs sampled at one rising clock edge show on the outputs after that same edge. Whenever src_sel is 0 (main), every other output is 0. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_x | input | XW | Pixel column within the active area |
| line_y | input | YW | Line within the active area |
| size_lg | input | 1 | 0 = small windows, 1 = large windows |
| xpos | input | 6 | Horizontal stack position step |
| ypos | input | 6 | Vertical stack position step |
| win_en | input | 4 | Per-slot enable, bit 0 = top |
| win_blank | input | 4 | Per-slot blank to black |
| live_sel | input | 2 | Live slot selector |
| border_code | input | 3 | Frame colour code |
| fill_code | input | 2 | Solid fill code, 00 = normal |
| src_sel | output | 3 | 0 main, 1 picture, 2 border, 3 fill, 4 black |
| win_idx | output | 2 | Slot of the current pixel |
| win_col | output | 7 | Column inside the picture |
| win_row | output | 7 | Row inside the picture |
| win_live | output | 1 | Pixel belongs to the live slot |
| color_code | output | 3 | Border or fill colour for the current code |

## Verification
The properties assume that the configuration and coordinate inputs are clean, known values at every clock edge. They also assume that pix_x and line_y stay inside ACT_W × ACT_H. The properties compare each output against the inputs from one cycle earlier, so they rely on exactly one register stage. The stimulus changes every input only on the falling clock edge. It keeps coordinates inside the active area, and it changes configuration only between pixels, never during one.

// File: rtl/pip_ovl_pkg.sv
package pip_ovl_pkg;

    // Window geometry
    localparam int PIC_W_S = 84;
    localparam int PIC_H_S = 53;
    localparam int PIC_W_L = 114;
    localparam int PIC_H_L = 71;
    localparam int BORD_X  = 3;
    localparam int BORD_Y  = 2;
    localparam int MAX_WIN = 4;
    localparam int WIN_L   = 3;
    localparam int POS_STEPS = 63;

    // Output field widths
    localparam int COLW = $clog2(PIC_W_L);
    localparam int ROWW = $clog2(PIC_H_L);
    localparam int IDXW = $clog2(MAX_WIN);

    typedef enum logic [2:0] {
        SRC_MAIN   = 3'd0,
        SRC_PIC    = 3'd1,
        SRC_BORDER = 3'd2,
        SRC_FILL   = 3'd3,
        SRC_BLACK  = 3'd4
    } src_e;

    typedef struct packed {
        src_e            src;
        logic [IDXW-1:0] win;
        logic [COLW-1:0] col;
        logic [ROWW-1:0] row;
        logic            live;
        logic [2:0]      color;
    } ovl_s;

endpackage

// File: rtl/pip_origin_calc.sv
module pip_origin_calc
    import pip_ovl_pkg::*;
#(
    parameter int XW    = 11,
    parameter int YW    = 10,
    parameter int ACT_W = 640,
    parameter int ACT_H = 480
) (
    input  logic            size_lg,
    input  logic [5:0]      xpos,
    input  logic [5:0]      ypos,
    output logic [XW-1:0]   x0,
    output logic [YW-1:0]   y0,
    output logic [COLW-1:0] pic_w,
    output logic [ROWW-1:0] pic_h,
    output logic [2:0]      nwin
);
    localparam int PX = XW + 6;
    localparam int PY = YW + 6;
    localparam int SPAN_XS = ACT_W - (PIC_W_S + 2 * BORD_X);
    localparam int SPAN_XL = ACT_W - (PIC_W_L + 2 * BORD_X);
    localparam int SPAN_YS = ACT_H - MAX_WIN * (PIC_H_S + 2 * BORD_Y);
    localparam int SPAN_YL = ACT_H - WIN_L * (PIC_H_L + 2 * BORD_Y);

    logic [PX-1:0] prod_x;
    logic [PY-1:0] prod_y;

    always_comb begin
        if (size_lg) begin
            prod_x = PX'(xpos) * PX'(SPAN_XL);
            prod_y = PY'(ypos) * PY'(SPAN_YL);
            pic_w  = COLW'(PIC_W_L);
            pic_h  = ROWW'(PIC_H_L);
            nwin   = 3'(WIN_L);
        end else begin
            prod_x = PX'(xpos) * PX'(SPAN_XS);
            prod_y = PY'(ypos) * PY'(SPAN_YS);
            pic_w  = COLW'(PIC_W_S);
            pic_h  = ROWW'(PIC_H_S);
            nwin   = 3'(MAX_WIN);
        end
        x0 = XW'(prod_x / PX'(POS_STEPS));
        y0 = YW'(prod_y / PY'(POS_STEPS));
    end

endmodule

// File: rtl/pip_slot_locate.sv
module pip_slot_locate
    import pip_ovl_pkg::*;
#(
    parameter int XW = 11,
    parameter int YW = 10
) (
    input  logic [XW-1:0]   pix_x,
    input  logic [YW-1:0]   line_y,
    input  logic [XW-1:0]   x0,
    input  logic [YW-1:0]   y0,
    input  logic [COLW-1:0] pic_w,
    input  logic [ROWW-1:0] pic_h,
    input  logic [2:0]      nwin,
    output logic            hit,
    output logic [IDXW-1:0] slot,
    output logic            in_pic,
    output logic [COLW-1:0] col,
    output logic [ROWW-1:0] row
);
    localparam int XE = XW + 1;
    localparam int YE = YW + 1;

    logic [XE-1:0]      dx;
    logic [XE-1:0]      box_w;
    logic               in_x;
    logic [YE-1:0]      cell_h;
    logic [YE-1:0]      row_start [MAX_WIN];
    logic [MAX_WIN-1:0] row_hit;
    logic [YE-1:0]      dy;
    logic               pic_x;
    logic               pic_y;

    assign box_w  = XE'(pic_w) + XE'(2 * BORD_X);
    assign dx     = XE'(pix_x) - XE'(x0);
    assign in_x   = (pix_x >= x0) && (dx < box_w);
    assign cell_h = YE'(pic_h) + YE'(2 * BORD_Y);

    // One row-range comparator per slot
    genvar k;
    generate
        for (k = 0; k < MAX_WIN; k++) begin : g_slot
            assign row_start[k] = YE'(y0) + YE'(k) * cell_h;
            assign row_hit[k]   = (3'(k) < nwin)
                                  && (YE'(line_y) >= row_start[k])
                                  && (YE'(line_y) < row_start[k] + cell_h);
        end
    endgenerate

    always_comb begin
        slot = '0;
        dy   = '0;
        for (int i = 0; i < MAX_WIN; i++) begin
            if (row_hit[i]) begin
                slot = IDXW'(i);
                dy   = YE'(line_y) - row_start[i];
            end
        end
        hit    = in_x && (|row_hit);
        pic_x  = (dx >= XE'(BORD_X)) && (dx < XE'(BORD_X) + XE'(pic_w));
        pic_y  = (dy >= YE'(BORD_Y)) && (dy < YE'(BORD_Y) + YE'(pic_h));
        in_pic = pic_x && pic_y;
        col    = COLW'(dx - XE'(BORD_X));
        row    = ROWW'(dy - YE'(BORD_Y));
    end

endmodule

// File: rtl/pip_pixel_mux.sv
module pip_pixel_mux
    import pip_ovl_pkg::*;
(
    input  logic            hit,
    input  logic [IDXW-1:0] slot,
    input  logic            in_pic,
    input  logic [COLW-1:0] col,
    input  logic [ROWW-1:0] row,
    input  logic            size_lg,
    input  logic [3:0]      win_en,
    input  logic [3:0]      win_blank,
    input  logic [1:0]      live_sel,
    input  logic [2:0]      border_code,
    input  logic [1:0]      fill_code,
    output ovl_s            pix_o
);
    logic [IDXW-1:0] live_idx;
    logic            slot_on;
    logic            bord_hidden;
    logic            is_live;

    always_comb begin
        // In large mode the fourth code falls back to the third slot
        live_idx    = (size_lg && live_sel == 2'b11) ? IDXW'(2) : IDXW'(live_sel);
        slot_on     = hit && win_en[slot];
        bord_hidden = (border_code[2:1] == 2'b01);
        is_live     = (slot == live_idx);
        pix_o       = '0;
        if (slot_on) begin
            if (!in_pic) begin
                if (!bord_hidden) begin
                    pix_o.src   = SRC_BORDER;
                    pix_o.color = border_code;
                    pix_o.win   = slot;
                    pix_o.live  = is_live;
                end
            end else begin
                pix_o.win  = slot;
                pix_o.live = is_live;
                if (win_blank[slot]) begin
                    pix_o.src = SRC_BLACK;
                end else if (fill_code != 2'b00) begin
                    pix_o.src   = SRC_FILL;
                    pix_o.color = {1'b0, fill_code};
                end else begin
                    pix_o.src = SRC_PIC;
                    pix_o.col = col;
                    pix_o.row = row;
                end
            end
        end
    end

endmodule

// File: rtl/pip_stack_overlay.sv
module pip_stack_overlay
    import pip_ovl_pkg::*;
#(
    parameter int XW    = 11,
    parameter int YW    = 10,
    parameter int ACT_W = 640,
    parameter int ACT_H = 480
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] pix_x,
    input  logic [YW-1:0] line_y,
    input  logic          size_lg,
    input  logic [5:0]    xpos,
    input  logic [5:0]    ypos,
    input  logic [3:0]    win_en,
    input  logic [3:0]    win_blank,
    input  logic [1:0]    live_sel,
    input  logic [2:0]    border_code,
    input  logic [1:0]    fill_code,
    output logic [2:0]    src_sel,
    output logic [1:0]    win_idx,
    output logic [6:0]    win_col,
    output logic [6:0]    win_row,
    output logic          win_live,
    output logic [2:0]    color_code
);
    logic [XW-1:0]   x0;
    logic [YW-1:0]   y0;
    logic [COLW-1:0] pic_w;
    logic [ROWW-1:0] pic_h;
    logic [2:0]      nwin;
    logic            hit;
    logic [IDXW-1:0] slot;
    logic            in_pic;
    logic [COLW-1:0] col;
    logic [ROWW-1:0] row;
    ovl_s            pix_c;
    ovl_s            ovl_d;
    ovl_s            ovl_q;

    pip_origin_calc #(
        .XW(XW), .YW(YW), .ACT_W(ACT_W), .ACT_H(ACT_H)
    ) u_origin (
        .size_lg(size_lg), .xpos(xpos), .ypos(ypos),
        .x0(x0), .y0(y0), .pic_w(pic_w), .pic_h(pic_h), .nwin(nwin)
    );

    pip_slot_locate #(.XW(XW), .YW(YW)) u_locate (
        .pix_x(pix_x), .line_y(line_y), .x0(x0), .y0(y0),
        .pic_w(pic_w), .pic_h(pic_h), .nwin(nwin),
        .hit(hit), .slot(slot), .in_pic(in_pic), .col(col), .row(row)
    );

    pip_pixel_mux u_mux (
        .hit(hit), .slot(slot), .in_pic(in_pic), .col(col), .row(row),
        .size_lg(size_lg), .win_en(win_en), .win_blank(win_blank),
        .live_sel(live_sel), .border_code(border_code), .fill_code(fill_code),
        .pix_o(pix_c)
    );

    always_comb begin
        ovl_d = pix_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovl_q <= '0;
        else        ovl_q <= ovl_d;
    end

    assign src_sel    = ovl_q.src;
    assign win_idx    = 2'(ovl_q.win);
    assign win_col    = 7'(ovl_q.col);
    assign win_row    = 7'(ovl_q.row);
    assign win_live   = ovl_q.live;
    assign color_code = ovl_q.color;

endmodule

// File: rtl/pip_stack_overlay_chk.sv
module pip_stack_overlay_chk #(
    parameter int XW = 11,
    parameter int YW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [XW-1:0] pix_x,
    input logic [YW-1:0] line_y,
    input logic          size_lg,
    input logic [5:0]    xpos,
    input logic [5:0]    ypos,
    input logic [3:0]    win_en,
    input logic [3:0]    win_blank,
    input logic [1:0]    live_sel,
    input logic [2:0]    border_code,
    input logic [1:0]    fill_code,
    input logic [2:0]    src_sel,
    input logic [1:0]    win_idx,
    input logic [6:0]    win_col,
    input logic [6:0]    win_row,
    input logic          win_live,
    input logic [2:0]    color_code
);
    // R8
    pic_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 3'd1) |-> (win_col < ($past(size_lg) ? 7'd114 : 7'd84))
                           && (win_row < ($past(size_lg) ? 7'd71 : 7'd53)));

    // R4
    all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(win_en) == 4'b0000) |-> (src_sel == 3'd0));

    // R1
    large_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(size_lg) && src_sel != 3'd0) |-> (win_idx != 2'd3));

    // R5
    blank_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 3'd1 || src_sel == 3'd3) |-> (($past(win_blank) & (4'b0001 << win_idx)) == 4'b0000));

    // R7
    fill_overrides_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 3'd1) |-> ($past(fill_code) == 2'b00));

    // R6
    hidden_border_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 3'd2) |-> ($past(border_code[2:1]) != 2'b01 && color_code == $past(border_code)));

    // R9
    live_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_live |-> (src_sel != 3'd0));

    // R10
    main_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 3'd0) |-> (win_idx == 2'd0 && win_col == 7'd0 && win_row == 7'd0
                               && !win_live && color_code == 3'd0));

    // R10
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel <= 3'd4);

endmodule

bind pip_stack_overlay pip_stack_overlay_chk #(.XW(XW), .YW(YW)) u_chk (.*);

// File: tb/sim_pip_stack_overlay.sv
module sim_pip_stack_overlay;
    localparam int XW = 11;
    localparam int YW = 10;
    localparam int ACT_W = 640;
    localparam int ACT_H = 480;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [XW-1:0] pix_x = '0;
    logic [YW-1:0] line_y = '0;
    logic size_lg = 1'b0;
    logic [5:0] xpos = '0, ypos = '0;
    logic [3:0] win_en = 4'hF, win_blank = 4'h0;
    logic [1:0] live_sel = 2'b00;
    logic [2:0] border_code = 3'b100;
    logic [1:0] fill_code = 2'b00;
    logic [2:0] src_sel;
    logic [1:0] win_idx;
    logic [6:0] win_col, win_row;
    logic win_live;
    logic [2:0] color_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int src; int win; int col; int row; int live; int color; string tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    pip_stack_overlay #(.XW(XW), .YW(YW), .ACT_W(ACT_W), .ACT_H(ACT_H)) u0 (
        .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .line_y(line_y),
        .size_lg(size_lg), .xpos(xpos), .ypos(ypos), .win_en(win_en),
        .win_blank(win_blank), .live_sel(live_sel), .border_code(border_code),
        .fill_code(fill_code), .src_sel(src_sel), .win_idx(win_idx),
        .win_col(win_col), .win_row(win_row), .win_live(win_live),
        .color_code(color_code)
    );

    // Expected value from the requirements
    function automatic exp_t model(int x, int y, string tag);
        exp_t e;
        int pw = size_lg ? 114 : 84;
        int ph = size_lg ? 71 : 53;
        int n  = size_lg ? 3 : 4;
        int sw = pw + 6;
        int ch = ph + 4;
        int x0 = (int'(xpos) * (ACT_W - sw)) / 63;
        int y0 = (int'(ypos) * (ACT_H - n * ch)) / 63;
        int k, dx, dy, lidx;
        bit inpic;
        e = '{0, 0, 0, 0, 0, 0, tag};
        if (x < x0 || x >= x0 + sw || y < y0 || y >= y0 + n * ch) return e;
        k  = (y - y0) / ch;
        dx = x - x0;
        dy = y - y0 - k * ch;
        if (!win_en[k]) return e;
        lidx  = (size_lg && live_sel == 2'b11) ? 2 : int'(live_sel);
        inpic = (dx >= 3) && (dx < 3 + pw) && (dy >= 2) && (dy < 2 + ph);
        if (!inpic) begin
            if (border_code[2:1] == 2'b01) return e;
            e.src = 2; e.color = int'(border_code);
        end else if (win_blank[k]) begin
            e.src = 4;
        end else if (fill_code != 2'b00) begin
            e.src = 3; e.color = int'(fill_code);
        end else begin
            e.src = 1; e.col = dx - 3; e.row = dy - 2;
        end
        e.win = k;
        e.live = (k == lidx) ? 1 : 0;
        return e;
    endfunction

    task automatic drv(int x, int y, string tag);
        @(negedge clk);
        pix_x  = XW'(x);
        line_y = YW'(y);
        q.push_back(model(x, y, tag));
    endtask

    task automatic cfg(bit lg, int xp, int yp, logic [3:0] en, logic [3:0] bl,
                       logic [1:0] lv, logic [2:0] bc, logic [1:0] fc);
        @(negedge clk);
        size_lg = lg; xpos = 6'(xp); ypos = 6'(yp); win_en = en; win_blank = bl;
        live_sel = lv; border_code = bc; fill_code = fc;
    endtask

    task automatic scan_line(int y, string tag);
        for (int x = 0; x < ACT_W; x++) drv(x, y, tag);
    endtask

    // Monitor: each item pushed at a falling edge is registered at the next rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (int'(src_sel) != e.src || int'(win_idx) != e.win || int'(win_col) != e.col
                    || int'(win_row) != e.row || int'(win_live) != e.live || int'(color_code) != e.color) begin
                    errors++;
                    $display("FAIL %s x=%0d y=%0d: got src=%0d win=%0d col=%0d row=%0d live=%0d color=%0d exp src=%0d win=%0d col=%0d row=%0d live=%0d color=%0d",
                             e.tag, pix_x, line_y, src_sel, win_idx, win_col, win_row, win_live, color_code,
                             e.src, e.win, e.col, e.row, e.live, e.color);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        pix_x = 11'd10; line_y = 10'd10;
        repeat (3) @(negedge clk);
        checks++;
        if ({src_sel, win_idx, win_col, win_row, win_live, color_code} != '0) begin
            errors++;
            $display("FAIL R10 reset: got src=%0d exp 0", src_sel);
        end
        rst_n = 1'b1;

        // R1 / R2 / R8: small mode, top-left
        cfg(0, 0, 0, 4'hF, 4'h0, 2'b00, 3'b100, 2'b00);
        drv(3, 2, "R8");
        drv(86, 54, "R1");
        drv(87, 2, "R2");
        drv(0, 0, "R2");
        drv(90, 0, "R1");
        drv(3, 57, "R2");
        drv(3, 59, "R8");
        drv(3, 227, "R2");
        drv(3, 228, "R1");
        // R9
        cfg(0, 0, 0, 4'hF, 4'h0, 2'b01, 3'b100, 2'b00);
        drv(10, 70, "R9");
        drv(10, 10, "R9");
        // R3
        cfg(0, 63, 63, 4'hF, 4'h0, 2'b00, 3'b100, 2'b00);
        drv(550, 252, "R3");
        drv(549, 252, "R3");
        drv(639, 479, "R3");
        cfg(0, 32, 20, 4'hF, 4'h0, 2'b00, 3'b100, 2'b00);
        drv(282, 82, "R3");
        drv(278, 82, "R3");
        // R4
        cfg(0, 0, 0, 4'b0101, 4'h0, 2'b00, 3'b100, 2'b00);
        drv(10, 70, "R4");
        drv(10, 130, "R4");
        cfg(0, 0, 0, 4'b0000, 4'h0, 2'b00, 3'b100, 2'b00);
        drv(10, 10, "R4");
        // R1 large
        cfg(1, 0, 0, 4'hF, 4'h0, 2'b11, 3'b100, 2'b00);
        drv(10, 10, "R1");
        drv(116, 72, "R1");
        drv(117, 10, "R2");
        drv(10, 224, "R2");
        drv(10, 225, "R4");
        drv(10, 160, "R9");
        // R5
        cfg(0, 0, 0, 4'hF, 4'b0010, 2'b00, 3'b100, 2'b00);
        drv(10, 70, "R5");
        drv(1, 70, "R5");
        // R6
        cfg(0, 0, 0, 4'hF, 4'h0, 2'b00, 3'b010, 2'b00);
        drv(1, 10, "R6");
        cfg(0, 0, 0, 4'hF, 4'h0, 2'b00, 3'b011, 2'b00);
        drv(1, 10, "R6");
        cfg(0, 0, 0, 4'hF, 4'h0, 2'b00, 3'b101, 2'b00);
        drv(1, 10, "R6");
        cfg(0, 0, 0, 4'hF, 4'h0, 2'b00, 3'b000, 2'b00);
        drv(1, 10, "R6");
        // R7
        cfg(0, 0, 0, 4'hF, 4'h0, 2'b00, 3'b100, 2'b10);
        drv(10, 10, "R7");
        cfg(0, 0, 0, 4'hF, 4'b0001, 2'b00, 3'b100, 2'b10);
        drv(10, 10, "R7");
        cfg(0, 0, 0, 4'hF, 4'h0, 2'b00, 3'b100, 2'b11);
        drv(10, 130, "R7");
        // Full-line sweeps across slot boundaries
        cfg(0, 10, 5, 4'b1011, 4'b0100, 2'b10, 3'b111, 2'b00);
        foreach (q[i]) begin end
        for (int yy = 18; yy < 24; yy++) scan_line(yy, "R2");
        scan_line(76, "R2");
        scan_line(77, "R4");
        scan_line(128, "R5");
        cfg(1, 40, 50, 4'b0111, 4'b0000, 2'b11, 3'b001, 2'b00);
        for (int yy = 200; yy < 204; yy++) scan_line(yy, "R8");
        scan_line(355, "R2");
        cfg(1, 40, 50, 4'b0111, 4'b0000, 2'b01, 3'b110, 2'b01);
        scan_line(280, "R7");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule